// File: doc/BRIEF.md
# Bus Address Parity Guard

This block sits beside the target address decoder of one PCI-style bus interface and checks the parity of every address phase it sees. An address phase is the first clock in which the active-low frame line is found asserted. In that clock the block captures the even parity of the 32 address/data lines and the 4 command/byte-enable lines, along with the decoder's hit flag. In the following clock it compares the captured parity with the parity line. The claim decision therefore waits for the parity result. It is presented in the clock after that, as a one-clock claim strobe with a permit flag, and DEVSEL logic uses that permit as its gate.

A mismatch always records a sticky detected-parity status bit. When the parity-error-response enable is set, a mismatch also withholds the claim, so the initiator can end in master abort. When both that enable and the system-error enable are set, the block drives an active-low system-error pulse for one clock, together with an output enable that models the open-drain line, and records a sticky signaled-system-error bit. Software clears status bits by a write-one-to-clear strobe with a per-bit mask.

Top module: `addr_parity_guard`

## Requirements
- R1: Parity is checked on every address phase, whatever the decoder's hit flag, and whatever the enable bits.
- R2: A parity error is flagged exactly when the parity line, sampled in the clock after the address phase, differs from the XOR of ad[31:0] and cbe_n[3:0] captured in the address phase (even parity).
- R3: claim_valid is high for exactly one clock, in the second clock after the address-phase clock. It is low at every other time.
- R4: With cfg_perr_resp set, a parity error forces claim_ok low in the claim_valid clock, even when the decoder hit.
- R5: With cfg_perr_resp clear, claim_ok in the claim_valid clock equals the decoder hit flag captured in the address phase, whether or not the parity was good.
- R6: status[0] (detected parity error) is set by any address parity error, independent of both enable bits.
- R7: serr_n goes low, and serr_oe goes high, for exactly one clock (the claim_valid clock). This happens only on a parity error with both cfg_perr_resp and cfg_serr_en set. status[1] (signaled system error) is set in that same clock.
- R8: Status bits are sticky. A strobe of sts_clr_we with sts_clr_mask bit k high clears status[k] only. A set event in the same clock wins over the clear.
- R9: After reset: claim_valid=0, claim_ok=0, serr_n=1, serr_oe=0, status=0.
- R10: Clocks in which frame_n stays low after the address phase are not address phases, so they produce neither a check nor a claim strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame line of the bus |
| ad | input | 32 | Address/data lines |
| cbe_n | input | 4 | Command/byte-enable lines |
| par | input | 1 | Even parity line, valid one clock after the lines it covers |
| decode_hit | input | 1 | Address decoder hit for the current address phase |
| cfg_perr_resp | input | 1 | Parity-error-response enable from the command register |
| cfg_serr_en | input | 1 | System-error enable from the command register |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status bits |
| sts_clr_mask | input | 2 | Per-bit clear mask (bit0 detected parity, bit1 signaled system error) |
| claim_valid | output | 1 | One-clock strobe marking the claim decision |
| claim_ok | output | 1 | Claim permitted (gates DEVSEL) while claim_valid is high |
| serr_n | output | 1 | Active-low system-error pulse |
| serr_oe | output | 1 | Output enable of the open-drain system-error driver |
| status | output | 2 | Sticky status: bit0 detected parity error, bit1 signaled system error |

## Verification
A table drives all sixteen combinations of the two enable bits, good or bad parity, and decoder hit or miss. This shows that claim suppression follows only the response enable, that the system-error pulse needs both enables, and that the detected bit follows parity alone. Each vector uses a different address and command pattern. A parity check that reads the wrong lines, or uses the wrong sense, therefore shows up in the good-parity rows. Directed cases then cover a long-held frame (the address phase must be detected on the edge only), the stickiness of each status bit, a clear of one bit at a time, and a set that meets a clear in the same clock.

// File: rtl/apg_pkg.sv
// Package: shared widths, status bit positions and the capture record
// passed between the address-phase stage and the response stage.
package apg_pkg;
    localparam int AD_W    = 32;
    localparam int CBE_W   = 4;
    localparam int STS_W   = 2;
    // Status bit positions, also used by the write-one-to-clear mask.
    localparam int STS_DET = 0;
    localparam int STS_SIG = 1;

    // Outcome of one address phase after its parity line has arrived.
    typedef struct packed {
        logic valid;   // a check completed in this clock
        logic err;     // parity mismatch
        logic hit;     // decoder hit captured in the address phase
    } chk_t;
endpackage

// File: rtl/apg_parity_tree.sv
// Module: apg_parity_tree
// Computes the XOR of a W-bit vector as a two-level tree: groups of GRP
// bits are reduced first, then the group results are combined.
// Assumes: purely combinational; W >= 1, GRP >= 1.
module apg_parity_tree #(
    parameter int W   = 36,
    parameter int GRP = 8
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int NGRP = (W + GRP - 1) / GRP;
    localparam int PADW = NGRP * GRP;

    logic [PADW-1:0] padded;
    logic [NGRP-1:0] part;

    // Zero-extend the input to a whole number of groups.
    always_comb begin
        padded         = '0;
        padded[W-1:0]  = vec;
    end

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            // Reduce one group of GRP bits.
            assign part[g] = ^padded[g*GRP +: GRP];
        end
    endgenerate

    // Combine the group results.
    assign odd = ^part;
endmodule

// File: rtl/apg_addr_phase.sv
// Module: apg_addr_phase
// Finds the address phase (first clock with frame_n low), captures the
// parity of ad/cbe_n and the decoder hit there, and one clock later
// compares the captured parity with the parity line.
// Assumes: frame_n is high for at least one clock between transactions;
// par in the clock after the address phase covers the address phase.
module apg_addr_phase
    import apg_pkg::*;
#(
    parameter int ADW  = AD_W,
    parameter int CBEW = CBE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic [ADW-1:0]  ad,
    input  logic [CBEW-1:0] cbe_n,
    input  logic            par,
    input  logic            decode_hit,
    output chk_t            chk
);
    localparam int VW = ADW + CBEW;

    logic frame_prev_n;
    logic addr_phase;
    logic lines_odd;
    logic pend_q;
    logic par_q;
    logic hit_q;

    apg_parity_tree #(.W(VW), .GRP(8)) u_tree (
        .vec ({ad, cbe_n}),
        .odd (lines_odd)
    );

    // Address phase: frame seen low now, high in the previous clock.
    assign addr_phase = !frame_n && frame_prev_n;

    // Track the frame line of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_prev_n <= 1'b1;
        else        frame_prev_n <= frame_n;
    end

    // Capture parity and decode result in the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            par_q  <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            pend_q <= addr_phase;
            if (addr_phase) begin
                par_q <= lines_odd;
                hit_q <= decode_hit;
            end
        end
    end

    // Compare with the late parity line in the clock after capture.
    always_comb begin
        chk.valid = pend_q;
        chk.err   = pend_q && (par != par_q);
        chk.hit   = hit_q;
    end
endmodule

// File: rtl/apg_response.sv
// Module: apg_response
// Turns a completed check into the claim strobe, the claim permit and
// the one-clock system-error pulse with its open-drain enable.
// Assumes: enable bits are sampled in the clock the check completes.
module apg_response
    import apg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  chk_t chk,
    input  logic cfg_perr_resp,
    input  logic cfg_serr_en,
    output logic claim_valid,
    output logic claim_ok,
    output logic serr_fire,
    output logic serr_n,
    output logic serr_oe
);
    logic block_claim;

    // Response enable turns a parity error into a withheld claim.
    assign block_claim = chk.err && cfg_perr_resp;
    // System error needs both enables.
    assign serr_fire   = chk.err && cfg_perr_resp && cfg_serr_en;

    // Register the claim decision as a one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_valid <= 1'b0;
            claim_ok    <= 1'b0;
        end else begin
            claim_valid <= chk.valid;
            claim_ok    <= chk.valid && chk.hit && !block_claim;
        end
    end

    // Drive the open-drain system-error line low for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serr_n  <= 1'b1;
            serr_oe <= 1'b0;
        end else begin
            serr_n  <= !serr_fire;
            serr_oe <= serr_fire;
        end
    end
endmodule

// File: rtl/apg_status.sv
// Module: apg_status
// Sticky status bits with a masked write-one-to-clear strobe; a set in
// the same clock as a clear wins.
// Assumes: set inputs are single-clock events.
module apg_status
    import apg_pkg::*;
#(
    parameter int N = STS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] sts
);
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_bit
            // Hold, set or clear one status bit.
            always_ff @(posedge clk) begin
                if (!rst_n)                   sts[k] <= 1'b0;
                else if (set[k])              sts[k] <= 1'b1;
                else if (clr_we && clr_mask[k]) sts[k] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/addr_parity_guard.sv
// Module: addr_parity_guard (top)
// Address parity guard for one bus interface: checks every address
// phase, gates the claim, signals system error and keeps sticky status.
// Assumes: synchronous active-low reset; frame_n active low.
module addr_parity_guard
    import apg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             par,
    input  logic             decode_hit,
    input  logic             cfg_perr_resp,
    input  logic             cfg_serr_en,
    input  logic             sts_clr_we,
    input  logic [STS_W-1:0] sts_clr_mask,
    output logic             claim_valid,
    output logic             claim_ok,
    output logic             serr_n,
    output logic             serr_oe,
    output logic [STS_W-1:0] status
);
    chk_t             chk;
    logic             serr_fire;
    logic [STS_W-1:0] sts_set;

    apg_addr_phase #(.ADW(AD_W), .CBEW(CBE_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .ad         (ad),
        .cbe_n      (cbe_n),
        .par        (par),
        .decode_hit (decode_hit),
        .chk        (chk)
    );

    apg_response u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk           (chk),
        .cfg_perr_resp (cfg_perr_resp),
        .cfg_serr_en   (cfg_serr_en),
        .claim_valid   (claim_valid),
        .claim_ok      (claim_ok),
        .serr_fire     (serr_fire),
        .serr_n        (serr_n),
        .serr_oe       (serr_oe)
    );

    // Route the error events to their status bit positions.
    always_comb begin
        sts_set          = '0;
        sts_set[STS_DET] = chk.err;
        sts_set[STS_SIG] = serr_fire;
    end

    apg_status #(.N(STS_W)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (sts_set),
        .clr_we   (sts_clr_we),
        .clr_mask (sts_clr_mask),
        .sts      (status)
    );
endmodule

// File: rtl/apg_checker.sv
// Module: apg_checker
// Temporal properties of the address parity guard, bound to the top.
module apg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic       decode_hit,
    input logic       cfg_perr_resp,
    input logic       cfg_serr_en,
    input logic       sts_clr_we,
    input logic [1:0] sts_clr_mask,
    input logic       claim_valid,
    input logic       claim_ok,
    input logic       serr_n,
    input logic       serr_oe,
    input logic [1:0] status,
    input logic       chk_err
);
    // R3: the claim strobe lasts one clock.
    p_claim_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |=> !claim_valid);

    // R5: a permitted claim needs a decoder hit two clocks earlier.
    p_claim_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_valid && claim_ok) |-> $past(decode_hit, 2));

    // R4: with response enabled, an error never yields a permitted claim.
    p_claim_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_err && cfg_perr_resp) |=> !claim_ok);

    // R7: the system-error pulse lasts one clock.
    p_serr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n);

    // R7: system error needs both enables in the previous clock.
    p_serr_enables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(cfg_serr_en && cfg_perr_resp));

    // R7: the open-drain enable goes with the active level.
    p_serr_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe |-> (!serr_n && status[1]));

    // R6: any error sets the detected bit in the next clock.
    p_det_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |=> status[0]);

    // R8: the detected bit holds unless cleared.
    p_det_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(sts_clr_we && sts_clr_mask[0])) |=> status[0]);

    // R8: the signaled bit holds unless cleared.
    p_sig_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(sts_clr_we && sts_clr_mask[1])) |=> status[1]);

    // R10: a check follows only a falling frame line two clocks earlier.
    p_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> (!$past(frame_n, 2) && $past(frame_n, 3)));
endmodule

bind addr_parity_guard apg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n       (frame_n),
    .decode_hit    (decode_hit),
    .cfg_perr_resp (cfg_perr_resp),
    .cfg_serr_en   (cfg_serr_en),
    .sts_clr_we    (sts_clr_we),
    .sts_clr_mask  (sts_clr_mask),
    .claim_valid   (claim_valid),
    .claim_ok      (claim_ok),
    .serr_n        (serr_n),
    .serr_oe       (serr_oe),
    .status        (status),
    .chk_err       (chk.err)
);

// File: tb/test_addr_parity_guard.sv
// Bench for addr_parity_guard: a vector table over enables, parity and
// decode, then directed reset and corner-case tests.
module test_addr_parity_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        par = 1'b0;
    logic        decode_hit = 1'b0;
    logic        cfg_perr_resp = 1'b0;
    logic        cfg_serr_en = 1'b0;
    logic        sts_clr_we = 1'b0;
    logic [1:0]  sts_clr_mask = '0;
    logic        claim_valid, claim_ok, serr_n, serr_oe;
    logic [1:0]  status;

    int n_chk = 0;
    int n_fail = 0;
    int n_cv;

    always #5 clk = ~clk;

    addr_parity_guard i_addr_parity_guard (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .par(par), .decode_hit(decode_hit), .cfg_perr_resp(cfg_perr_resp),
        .cfg_serr_en(cfg_serr_en), .sts_clr_we(sts_clr_we),
        .sts_clr_mask(sts_clr_mask), .claim_valid(claim_valid),
        .claim_ok(claim_ok), .serr_n(serr_n), .serr_oe(serr_oe),
        .status(status)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [3:0]  c;
        logic        bad;
        logic        hit;
        logic        pr;
        logic        se;
        logic        x_claim;
        logic        x_serr;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{32'h0000_0000, 4'h6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h1234_5678, 4'h7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h8000_0001, 4'ha, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'hdead_beef, 4'hb, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'hffff_ffff, 4'hf, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0100, 4'h2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{32'h5555_aaaa, 4'h3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0f0f_0f0f, 4'h6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{32'hc000_0000, 4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0001, 4'hc, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{32'h7fff_fffe, 4'he, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h1357_9bdf, 4'h6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h2468_ace0, 4'ha, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0001_0000, 4'h1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'ha5a5_5a5a, 4'h7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'h8421_1248, 4'hb, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_sts(input logic [1:0] m);
        @(negedge clk);
        sts_clr_we = 1'b1; sts_clr_mask = m;
        @(negedge clk);
        sts_clr_we = 1'b0; sts_clr_mask = '0;
    endtask

    // One address phase; bad flips the parity line. Checks the claim
    // clock (R3) then returns in the clock after it.
    task automatic txn(input logic [31:0] a, input logic [3:0] c,
                       input logic bad, input logic hit,
                       input logic exp_claim, input logic exp_serr,
                       input logic clr_with_par);
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = c; decode_hit = hit;
        @(negedge clk);
        frame_n = 1'b1; ad = ~a; decode_hit = ~hit;
        par = (^{a, c}) ^ bad;
        if (clr_with_par) begin sts_clr_we = 1'b1; sts_clr_mask = 2'b11; end
        check("R3 no strobe before claim clock", claim_valid, 1'b0);
        @(negedge clk);
        sts_clr_we = 1'b0; sts_clr_mask = '0;
        check("R3 claim strobe", claim_valid, 1'b1);
        check("R4/R5 claim_ok", claim_ok, exp_claim);
        check("R7 serr_n", serr_n, !exp_serr);
        check("R7 serr_oe", serr_oe, exp_serr);
        @(negedge clk);
        check("R3 strobe one clock", claim_valid, 1'b0);
        check("R7 serr one clock", serr_n, 1'b1);
    endtask

    initial begin
        #50000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 claim_valid", claim_valid, 1'b0);
        check("R9 claim_ok", claim_ok, 1'b0);
        check("R9 serr_n", serr_n, 1'b1);
        check("R9 serr_oe", serr_oe, 1'b0);
        check("R9 status", status, 2'b00);
        rst_n = 1'b1;

        // Table: R1 R2 R4 R5 R6 R7 over all enable/parity/decode mixes.
        for (int i = 0; i < 16; i++) begin
            cfg_perr_resp = VEC[i].pr;
            cfg_serr_en   = VEC[i].se;
            txn(VEC[i].a, VEC[i].c, VEC[i].bad, VEC[i].hit,
                VEC[i].x_claim, VEC[i].x_serr, 1'b0);
            check("R1/R2/R6 detected bit", status[0], VEC[i].bad);
            check("R7 signaled bit", status[1], VEC[i].x_serr);
            clear_sts(2'b11);
            check("R8 cleared", status, 2'b00);
        end

        // R8: sticky across a good transaction, then per-bit clear.
        cfg_perr_resp = 1'b1; cfg_serr_en = 1'b1;
        txn(32'h0000_0040, 4'h6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        txn(32'h0000_0080, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 sticky after good txn", status, 2'b11);
        clear_sts(2'b01);
        check("R8 clear bit0 only", status, 2'b10);
        clear_sts(2'b10);
        check("R8 clear bit1", status, 2'b00);

        // R8: a set meets a clear in the same clock; the set wins.
        txn(32'h0000_00c0, 4'h7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R8 set wins over clear", status, 2'b11);
        clear_sts(2'b11);

        // R10: frame held low for several clocks; one check only.
        n_cv = 0;
        @(negedge clk);
        frame_n = 1'b0; ad = 32'h0000_1000; cbe_n = 4'h6; decode_hit = 1'b1;
        @(negedge clk);
        par = ^{32'h0000_1000, 4'h6};
        ad = 32'h0000_0007; cbe_n = 4'h0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            par = ~(^{ad, cbe_n});
            if (claim_valid) n_cv++;
        end
        frame_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (claim_valid) n_cv++;
        end
        check("R10 one strobe for long frame", n_cv, 1);
        check("R10 no error from data clocks", status, 2'b00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule